// File: doc/BRIEF.md
# Programmable Pulse Dialer

This block turns a stream of dial digits into open/close pulse trains on a hook relay. Each digit enters through a valid/ready handshake. It is translated into a pulse count and played out as a number of open (break) intervals. Each break is followed by a closed (make) interval. A pause follows the last pulse before the next digit is taken. All timing is counted in events of a one-millisecond strobe, which an external prescaler supplies.

Break and make lengths are set in milliseconds. The pause is set in units of ten milliseconds. One input chooses between two digit-to-count tables, so that national variants can be served.

Back-pressure: `dig_ready` is high only while the dialer is idle. A digit is taken in any cycle where `dig_valid` and `dig_ready` are both high. `dig_ready` then stays low until the pause after that digit has run out. A source holding `dig_valid` with a low `dig_ready` keeps its digit until it is taken. The timing inputs are read each time a phase starts, so they must be held steady while `busy` is high.

Top module: `pulse_dialer`

## Requirements
- R1: During and right after reset, `relay_closed` is 1, `dig_ready` is 1, and `busy`, `done` and `bad_digit` are 0.
- R2: A digit is taken when `dig_valid` and `dig_ready` are both high. For a legal code, `dig_ready` is low and `busy` is high from the next cycle until the pause after that digit ends.
- R3: With `alt_map` = 0, code 1 to 9 yields that many pulses, and code 0 yields 10 pulses.
- R4: With `alt_map` = 1, code N (0 to 9) yields N+1 pulses.
- R5: Each pulse opens the relay (`relay_closed` = 0) for `break_ms` strobe events, then closes it for `make_ms` strobe events. At all other times the relay is closed. Events are counted in the cycles after a phase starts, and the phase ends in the cycle after its last counted event.
- R6: After the last break, the relay stays closed and `busy` stays high for `make_ms` + 10 × `gap_10ms` strobe events before `dig_ready` returns.
- R7: A timing setting of 0 acts as a setting of 1.
- R8: Codes 10 to 15 are taken but produce no pulse. `bad_digit` pulses high for one cycle after acceptance, while `busy` stays 0 and `dig_ready` stays 1.
- R9: `done` is high for exactly one cycle: the first cycle in which `busy` is 0 again after a digit.
- R10: `relay_closed` changes only in a cycle that follows a strobe event or a digit acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| dig_valid | input | 1 | Digit offered |
| dig_code | input | 4 | Digit code, 0 to 9 legal |
| dig_ready | output | 1 | Dialer can take a digit |
| make_ms | input | MAKE_W | Closed interval per pulse, ms |
| break_ms | input | BREAK_W | Open interval per pulse, ms |
| gap_10ms | input | GAP_W | Pause after a digit, 10 ms units |
| alt_map | input | 1 | 0: zero gives ten pulses; 1: N gives N+1 |
| relay_closed | output | 1 | Hook relay drive, 1 = closed (off hook) |
| busy | output | 1 | A digit is being dialled |
| done | output | 1 | One-cycle strobe when a digit finishes |
| bad_digit | output | 1 | One-cycle strobe for a rejected code |

## Verification
The bench builds the dialer with MAKE_W and BREAK_W set to 7 and GAP_W set to 4. This keeps the all-ones settings (127 ms and a 150 ms pause) short enough to reach in a directed case. The same settings leave room for random intervals from zero upward. Because the strobe comes every fourth clock, the timer sees both runs of idle cycles and strobes that coincide with acceptance and with phase ends. Together, these exercise the zero-as-one rule, the longest pause value and both maps at their ten-pulse ends.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [1:0] {
    PD_IDLE  = 2'd0,
    PD_OPEN  = 2'd1,
    PD_SHUT  = 2'd2,
    PD_PAUSE = 2'd3
  } pd_state_e;

  localparam int unsigned CODE_W  = 4;
  localparam int unsigned COUNT_W = 4;
  localparam int unsigned GAP_MUL = 10;

endpackage

// File: rtl/pd_digit_map.sv
module pd_digit_map
  import pd_pkg::*;
#(
  parameter bit ALT_EN = 1'b1
) (
  input  logic [CODE_W-1:0]  code,
  input  logic               alt_sel,
  output logic [COUNT_W-1:0] count,
  output logic               legal
);

  logic [COUNT_W-1:0] std_count;

  assign legal     = (code <= CODE_W'(9));
  assign std_count = (code == '0) ? COUNT_W'(10) : COUNT_W'(code);

  generate
    if (ALT_EN) begin : g_alt
      logic [COUNT_W-1:0] alt_count;
      assign alt_count = COUNT_W'(code) + COUNT_W'(1);
      assign count     = alt_sel ? alt_count : std_count;
    end else begin : g_std
      logic unused_alt;
      assign unused_alt = alt_sel;
      assign count      = std_count;
    end
  endgenerate

endmodule

// File: rtl/pd_tick_timer.sv
module pd_tick_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          tick,
  output logic          expire
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expire = tick && (cnt_q <= TW'(1));

endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import pd_pkg::*;
#(
  parameter int unsigned MW = 8,
  parameter int unsigned BW = 8,
  parameter int unsigned GW = 6,
  parameter int unsigned TW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_ok,
  input  logic               take_bad,
  input  logic [COUNT_W-1:0] count,
  input  logic               expire,
  input  logic [MW-1:0]      make_ms,
  input  logic [BW-1:0]      break_ms,
  input  logic [GW-1:0]      gap_10ms,
  output logic               load,
  output logic [TW-1:0]      load_val,
  output pd_state_e          state,
  output logic               done,
  output logic               bad_digit
);

  pd_state_e          state_q, state_d;
  logic [COUNT_W-1:0] left_q;
  logic               done_q, bad_q;
  logic [TW-1:0]      make_len, break_len, gap_unit, gap_len;

  assign make_len  = (make_ms  == '0) ? TW'(1) : TW'(make_ms);
  assign break_len = (break_ms == '0) ? TW'(1) : TW'(break_ms);
  assign gap_unit  = (gap_10ms == '0) ? TW'(1) : TW'(gap_10ms);
  assign gap_len   = (gap_unit << 3) + (gap_unit << 1);

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      PD_IDLE: begin
        if (take_ok) begin
          state_d  = PD_OPEN;
          load     = 1'b1;
          load_val = break_len;
        end
      end
      PD_OPEN: begin
        if (expire) begin
          state_d  = PD_SHUT;
          load     = 1'b1;
          load_val = make_len;
        end
      end
      PD_SHUT: begin
        if (expire) begin
          load = 1'b1;
          if (left_q <= COUNT_W'(1)) begin
            state_d  = PD_PAUSE;
            load_val = gap_len;
          end else begin
            state_d  = PD_OPEN;
            load_val = break_len;
          end
        end
      end
      PD_PAUSE: begin
        if (expire) begin
          state_d = PD_IDLE;
        end
      end
      default: state_d = PD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PD_IDLE;
      left_q  <= '0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == PD_PAUSE) && expire;
      bad_q   <= take_bad;
      if (state_q == PD_IDLE && take_ok) begin
        left_q <= count;
      end else if (state_q == PD_SHUT && expire && left_q > COUNT_W'(1)) begin
        left_q <= left_q - COUNT_W'(1);
      end
    end
  end

  assign state     = state_q;
  assign done      = done_q;
  assign bad_digit = bad_q;

endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer
  import pd_pkg::*;
#(
  parameter int unsigned MAKE_W  = 8,
  parameter int unsigned BREAK_W = 8,
  parameter int unsigned GAP_W   = 6,
  parameter bit          ALT_EN  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ms_tick,
  input  logic               dig_valid,
  input  logic [3:0]         dig_code,
  output logic               dig_ready,
  input  logic [MAKE_W-1:0]  make_ms,
  input  logic [BREAK_W-1:0] break_ms,
  input  logic [GAP_W-1:0]   gap_10ms,
  input  logic               alt_map,
  output logic               relay_closed,
  output logic               busy,
  output logic               done,
  output logic               bad_digit
);

  localparam int unsigned PULSE_W = (MAKE_W > BREAK_W) ? MAKE_W : BREAK_W;
  localparam int unsigned TIMER_W = (PULSE_W > GAP_W + 4) ? PULSE_W : GAP_W + 4;

  pd_state_e           state;
  logic                take, take_ok, take_bad, legal, load, expire;
  logic [COUNT_W-1:0]  count;
  logic [TIMER_W-1:0]  load_val;

  assign dig_ready    = (state == PD_IDLE);
  assign take         = dig_valid && dig_ready;
  assign take_ok      = take && legal;
  assign take_bad     = take && !legal;
  assign busy         = (state != PD_IDLE);
  assign relay_closed = (state != PD_OPEN);

  pd_digit_map #(.ALT_EN(ALT_EN)) u_map (
    .code    (dig_code),
    .alt_sel (alt_map),
    .count   (count),
    .legal   (legal)
  );

  pd_tick_timer #(.TW(TIMER_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .tick     (ms_tick),
    .expire   (expire)
  );

  pd_seq #(
    .MW (MAKE_W),
    .BW (BREAK_W),
    .GW (GAP_W),
    .TW (TIMER_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_ok   (take_ok),
    .take_bad  (take_bad),
    .count     (count),
    .expire    (expire),
    .make_ms   (make_ms),
    .break_ms  (break_ms),
    .gap_10ms  (gap_10ms),
    .load      (load),
    .load_val  (load_val),
    .state     (state),
    .done      (done),
    .bad_digit (bad_digit)
  );

endmodule

// File: rtl/pd_checker.sv
module pd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic       dig_valid,
  input logic [3:0] dig_code,
  input logic       dig_ready,
  input logic       relay_closed,
  input logic       busy,
  input logic       done,
  input logic       bad_digit
);

  p_take_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid && dig_ready && dig_code <= 4'd9) |=> (busy && !dig_ready));

  p_open_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !relay_closed |-> busy);

  p_reject_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid && dig_ready && dig_code > 4'd9) |=> (bad_digit && !busy && dig_ready));

  p_done_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_relay_paced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ms_tick && !(dig_valid && dig_ready)) |=> $stable(relay_closed));

endmodule

bind pulse_dialer pd_checker u_pd_checker (.*);

// File: tb/test_pulse_dialer.sv
module test_pulse_dialer;

  localparam int MW = 7;
  localparam int BW = 7;
  localparam int GW = 4;
  localparam int TICK_DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ms_tick = 1'b0;
  logic          dig_valid = 1'b0;
  logic [3:0]    dig_code = '0;
  logic          dig_ready;
  logic [MW-1:0] make_ms = '0;
  logic [BW-1:0] break_ms = '0;
  logic [GW-1:0] gap_10ms = '0;
  logic          alt_map = 1'b0;
  logic          relay_closed, busy, done, bad_digit;

  int n_chk = 0;
  int n_fail = 0;
  int phase = 0;

  always #10 clk = ~clk;

  pulse_dialer #(.MAKE_W(MW), .BREAK_W(BW), .GAP_W(GW), .ALT_EN(1'b1)) i_pulse_dialer (
    .clk (clk), .rst_n (rst_n), .ms_tick (ms_tick), .dig_valid (dig_valid),
    .dig_code (dig_code), .dig_ready (dig_ready), .make_ms (make_ms),
    .break_ms (break_ms), .gap_10ms (gap_10ms), .alt_map (alt_map),
    .relay_closed (relay_closed), .busy (busy), .done (done), .bad_digit (bad_digit)
  );

  initial begin
    forever begin
      @(posedge clk);
      #3;
      phase   = (phase + 1) % TICK_DIV;
      ms_tick = (phase == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int d, input bit alt);
    if (alt) return d + 1;
    return (d == 0) ? 10 : d;
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic dial(input int d, input bit alt, input int mk, input int bk, input int gp);
    int runs, lowt, hight, bad_low, bad_high, rdy_viol;
    bit in_low;
    @(negedge clk);
    make_ms = MW'(mk); break_ms = BW'(bk); gap_10ms = GW'(gp); alt_map = alt;
    while (!dig_ready) @(negedge clk);
    dig_valid = 1'b1;
    dig_code  = 4'(d);
    @(negedge clk);
    dig_valid = 1'b0;
    if (d > 9) begin
      check(bad_digit == 1'b1, "R8 bad_digit strobe", int'(bad_digit), 1);
      check(!busy && dig_ready, "R8 stays idle", int'(busy), 0);
      bad_low = 0;
      for (int i = 0; i < 20; i++) begin
        if (!relay_closed || busy) bad_low++;
        @(negedge clk);
      end
      check(bad_low == 0, "R8 no pulses for rejected code", bad_low, 0);
      return;
    end
    runs = 0; lowt = 0; hight = 0; bad_low = 0; bad_high = 0; rdy_viol = 0; in_low = 1'b0;
    check(busy && !dig_ready, "R2 ready drops after take", int'(dig_ready), 0);
    while (busy) begin
      if (dig_ready) rdy_viol++;
      if (!relay_closed) begin
        if (!in_low) begin
          if (runs > 0 && hight != eff(mk)) bad_high++;
          runs++;
          lowt   = 0;
          in_low = 1'b1;
        end
        lowt += int'(ms_tick);
      end else begin
        if (in_low) begin
          if (lowt != eff(bk)) bad_low++;
          in_low = 1'b0;
          hight  = 0;
        end
        hight += int'(ms_tick);
      end
      @(negedge clk);
    end
    check(runs == exp_pulses(d, alt), alt ? "R4 alternate pulse count" : "R3 default pulse count",
          runs, exp_pulses(d, alt));
    check(bad_low == 0, "R5 break length", bad_low, 0);
    check(bad_high == 0, "R5 make length", bad_high, 0);
    check(hight == eff(mk) + 10 * eff(gp), "R6 make plus pause", hight, eff(mk) + 10 * eff(gp));
    check(rdy_viol == 0, "R2 ready low while busy", rdy_viol, 0);
    check(done == 1'b1 && dig_ready, "R9 done with ready return", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1d5e_a7c3);
    repeat (3) @(negedge clk);
    check(relay_closed && dig_ready && !busy && !done && !bad_digit, "R1 state in reset",
          int'(relay_closed), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(relay_closed && dig_ready && !busy, "R1 state after reset", int'(busy), 0);

    dial(0, 1'b0, 3, 5, 1);
    dial(1, 1'b0, 4, 2, 2);
    dial(0, 1'b1, 2, 2, 1);
    dial(9, 1'b1, 1, 3, 1);
    dial(9, 1'b0, 2, 1, 1);
    dial(3, 1'b0, 0, 0, 0);   // R7 zero settings act as one
    dial(1, 1'b0, 127, 127, 15);
    dial(10, 1'b0, 2, 2, 1);
    dial(15, 1'b1, 2, 2, 1);

    for (int i = 0; i < 30; i++) begin
      dial(int'($urandom % 13), 1'($urandom), int'($urandom % 21),
           int'($urandom % 21), int'($urandom % 6));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule